// File: doc/BRIEF.md
# Rotate Unit with Carry Flag

This block is the rotate stage of an integer execute datapath. In one combinational pass it rotates an 8, 16 or 32 bit operand left or right. It either rotates the operand on itself or through the carry flag. From the same inputs it produces the updated carry flag, the updated overflow flag and a flag-write enable for the flag registers downstream.

The raw count input is eight bits wide, and only its low five bits take effect. The five-bit value is called the masked count. For a rotate through carry on a narrow operand, the masked count is then reduced modulo the ring length: 9 for bytes and 17 for halfwords. The carry bit counts as one position of that ring. A masked count of zero is a no-op for the result and for both flags, and the flag-write enable is low. The overflow flag is computed only for a masked count of one. For larger counts the incoming overflow flag passes through unchanged, so the output is deterministic.

The block has no state. Each operand width has its own rotate lane, and the size select picks one lane. Three small modules then share the remaining work: one prepares the count, one maps the lanes, and one forms the flags.

Top module: `rot_flag_unit`

## Requirements
- R1: Only bits [4:0] of `i_count` affect any output. Bits [7:5] are ignored, so the masked count is 0 to 31.
- R2: Size select 2'b00 means an 8-bit operand, 2'b01 a 16-bit operand, and 2'b10 or 2'b11 a 32-bit operand. Result bits above the operand width are zero, and operand bits above the width are ignored.
- R3: Op 2'b00 (plain left) rotates the operand left by the masked count modulo the width. For a nonzero masked count, the carry output equals bit 0 of the result.
- R4: Op 2'b01 (plain right) rotates the operand right by the masked count modulo the width. For a nonzero masked count, the carry output equals the top bit of the result at that width.
- R5: Op 2'b10 (left through carry) rotates the ring {carry, operand} left by the masked count modulo 9 for bytes and modulo 17 for halfwords, and by the masked count unchanged for words. The top operand bit moves into the carry, and the carry moves into bit 0.
- R6: Op 2'b11 (right through carry) rotates the same ring right with the same count reduction. Bit 0 moves into the carry, and the carry moves into the top operand bit.
- R7: With a masked count of one and a left op, the overflow output is the new carry XOR the top result bit.
- R8: With a masked count of one and a right op, the overflow output is the XOR of the two highest result bits.
- R9: With a masked count above one, the overflow output equals the overflow input.
- R10: With a masked count of zero, the result equals the operand (zero-extended above the width), the carry output equals the carry input, and the overflow output equals the overflow input.
- R11: The flag-write enable is high exactly when the masked count is nonzero.
- R12: A plain rotate by a nonzero multiple of the width returns the operand unchanged, and the carry output still takes the last bit wrapped (bit 0 for left, the top bit for right).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_operand | input | 32 | Operand; only the low bits of the selected width are used |
| i_size | input | 2 | Operand width select |
| i_count | input | 8 | Raw rotate count |
| i_op | input | 2 | Rotate operation select |
| i_carry | input | 1 | Incoming carry flag |
| i_ovf | input | 1 | Incoming overflow flag |
| o_result | output | 32 | Rotated operand, zero above the width |
| o_carry | output | 1 | Updated carry flag |
| o_ovf | output | 1 | Updated overflow flag |
| o_flag_we | output | 1 | Flag-write enable |

## Verification
Counts of 9 and 17 on carry rotates are the main targets. A design that skipped the ring reduction would rotate one position too far and lose the incoming carry. Plain rotates by 8, 16 and 24 on narrow operands are checked next. A unit that tied the carry to "no rotation happened" would leave the carry stale instead of copying the wrapped bit. Raw counts of 32, 64 and up test the masking. A unit that looked at the upper count bits would rotate where it must not, or would raise the flag-write enable on a no-op. Finally, every count from 0 to 255 on every size and operation is compared with a bit-by-bit stepping model. That sweep catches a wrong overflow source at a count of one and a sign-bit tap taken from the wrong lane.

// File: rtl/rot_pkg.sv
package rot_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } rot_size_e;

    typedef enum logic [1:0] {
        OP_ROL = 2'b00,
        OP_ROR = 2'b01,
        OP_RCL = 2'b10,
        OP_RCR = 2'b11
    } rot_op_e;

    localparam int LANES = 3;

    function automatic int lane_of(input logic [1:0] sz);
        case (sz)
            2'b00:   return 0;
            2'b01:   return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/rot_count_prep.sv
module rot_count_prep #(
    parameter int CNT_W  = 8,
    parameter int MASK_W = 5
) (
    input  logic [CNT_W-1:0]  i_count,
    output logic [MASK_W-1:0] o_masked,
    output logic              o_zero,
    output logic              o_one
);
    // R1: upper count bits never reach the datapath
    logic hi_bits_unused;

    always_comb begin
        o_masked       = i_count[MASK_W-1:0];
        o_zero         = (o_masked == '0);
        o_one          = (o_masked == MASK_W'(1));
        hi_bits_unused = ^i_count[CNT_W-1:MASK_W];
    end
endmodule

// File: rtl/rot_ring.sv
module rot_ring #(
    parameter int W  = 8,
    parameter int MW = 5
) (
    input  logic [W-1:0]  i_val,
    input  logic          i_cin,
    input  logic [MW-1:0] i_m,
    input  logic          i_left,
    input  logic          i_thru,
    output logic [W-1:0]  o_val,
    output logic          o_cout
);
    localparam int EW  = W + 1;
    localparam int PIW = $clog2(W);
    localparam int EIW = $clog2(EW);

    int             k_plain;
    int             k_ring;
    logic [PIW-1:0] p_idx;
    logic [EIW-1:0] e_idx;
    logic [W-1:0]   plain;
    logic [EW-1:0]  ring;
    logic [EW-1:0]  ring_rot;

    always_comb begin
        // R3 R4 R12: plain rotate count reduced by the width
        k_plain = int'(i_m) % W;
        // R5 R6: carry ring is one bit longer than the operand
        k_ring  = int'(i_m) % EW;
        ring    = {i_cin, i_val};
        p_idx   = '0;
        e_idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (i_left) p_idx = PIW'((i + W - k_plain) % W);
            else        p_idx = PIW'((i + k_plain) % W);
            plain[i] = i_val[p_idx];
        end
        for (int i = 0; i < EW; i++) begin
            if (i_left) e_idx = EIW'((i + EW - k_ring) % EW);
            else        e_idx = EIW'((i + k_ring) % EW);
            ring_rot[i] = ring[e_idx];
        end
        if (i_thru) begin
            o_val  = ring_rot[W-1:0];
            o_cout = ring_rot[W];
        end else begin
            o_val  = plain;
            o_cout = i_left ? plain[0] : plain[W-1];
        end
    end
endmodule

// File: rtl/rot_flag_gen.sv
module rot_flag_gen (
    input  logic i_zero,
    input  logic i_one,
    input  logic i_left,
    input  logic i_cout,
    input  logic i_msb,
    input  logic i_msb2,
    input  logic i_carry,
    input  logic i_ovf,
    output logic o_carry,
    output logic o_ovf,
    output logic o_we
);
    always_comb begin
        o_we = ~i_zero;
        if (i_zero) begin
            o_carry = i_carry;
            o_ovf   = i_ovf;
        end else begin
            o_carry = i_cout;
            if (i_one) o_ovf = i_left ? (i_cout ^ i_msb) : (i_msb ^ i_msb2);
            else       o_ovf = i_ovf;
        end
    end
endmodule

// File: rtl/rot_flag_unit.sv
module rot_flag_unit
    import rot_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int MASK_W = 5
) (
    input  logic [DATA_W-1:0] i_operand,
    input  logic [1:0]        i_size,
    input  logic [CNT_W-1:0]  i_count,
    input  logic [1:0]        i_op,
    input  logic              i_carry,
    input  logic              i_ovf,
    output logic [DATA_W-1:0] o_result,
    output logic              o_carry,
    output logic              o_ovf,
    output logic              o_flag_we
);
    logic [MASK_W-1:0] m;
    logic              m_zero;
    logic              m_one;
    logic              go_left;
    logic              thru;

    logic [DATA_W-1:0] lane_val  [LANES];
    logic              lane_cout [LANES];
    logic              lane_msb  [LANES];
    logic              lane_msb2 [LANES];

    logic [DATA_W-1:0] sel_val;
    logic              sel_cout;
    logic              sel_msb;
    logic              sel_msb2;

    rot_count_prep #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u_prep (
        .i_count (i_count),
        .o_masked(m),
        .o_zero  (m_zero),
        .o_one   (m_one)
    );

    always_comb begin
        go_left = (i_op == OP_ROL) || (i_op == OP_RCL);
        thru    = (i_op == OP_RCL) || (i_op == OP_RCR);
    end

    // one lane per operand width: DATA_W/4, DATA_W/2, DATA_W
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int GW = DATA_W >> (LANES - 1 - g);
        logic [GW-1:0] val;
        logic          cout;

        rot_ring #(.W(GW), .MW(MASK_W)) u_ring (
            .i_val (i_operand[GW-1:0]),
            .i_cin (i_carry),
            .i_m   (m),
            .i_left(go_left),
            .i_thru(thru),
            .o_val (val),
            .o_cout(cout)
        );

        always_comb begin
            lane_val[g]  = DATA_W'(val);
            lane_cout[g] = cout;
            lane_msb[g]  = val[GW-1];
            lane_msb2[g] = val[GW-2];
        end
    end

    // R2: lane pick by size; narrow lanes are already zero-extended
    always_comb begin
        unique case (lane_of(i_size))
            0: begin
                sel_val = lane_val[0]; sel_cout = lane_cout[0];
                sel_msb = lane_msb[0]; sel_msb2 = lane_msb2[0];
            end
            1: begin
                sel_val = lane_val[1]; sel_cout = lane_cout[1];
                sel_msb = lane_msb[1]; sel_msb2 = lane_msb2[1];
            end
            default: begin
                sel_val = lane_val[2]; sel_cout = lane_cout[2];
                sel_msb = lane_msb[2]; sel_msb2 = lane_msb2[2];
            end
        endcase
    end

    assign o_result = sel_val;

    rot_flag_gen u_flags (
        .i_zero (m_zero),
        .i_one  (m_one),
        .i_left (go_left),
        .i_cout (sel_cout),
        .i_msb  (sel_msb),
        .i_msb2 (sel_msb2),
        .i_carry(i_carry),
        .i_ovf  (i_ovf),
        .o_carry(o_carry),
        .o_ovf  (o_ovf),
        .o_we   (o_flag_we)
    );
endmodule

// File: rtl/rot_flag_unit_chk.sv
module rot_flag_unit_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic [DATA_W-1:0] i_operand,
    input logic [1:0]        i_size,
    input logic [CNT_W-1:0]  i_count,
    input logic [1:0]        i_op,
    input logic              i_carry,
    input logic              i_ovf,
    input logic [DATA_W-1:0] o_result,
    input logic              o_carry,
    input logic              o_ovf,
    input logic              o_flag_we
);
    logic [4:0]        mc;
    logic [DATA_W-1:0] wmask;
    logic              top;
    logic              top2;

    always_comb begin
        mc = i_count[4:0];
        case (i_size)
            2'b00:   begin wmask = DATA_W'({(DATA_W/4){1'b1}}); top = o_result[DATA_W/4-1]; top2 = o_result[DATA_W/4-2]; end
            2'b01:   begin wmask = DATA_W'({(DATA_W/2){1'b1}}); top = o_result[DATA_W/2-1]; top2 = o_result[DATA_W/2-2]; end
            default: begin wmask = '1; top = o_result[DATA_W-1]; top2 = o_result[DATA_W-2]; end
        endcase

        // R11
        flag_we_chk: assert (o_flag_we == (mc != 5'd0));
        // R2
        upper_zero_chk: assert ((o_result & ~wmask) == '0);
        if (mc == 5'd0) begin
            // R10
            zero_count_chk: assert (o_result == (i_operand & wmask) && o_carry == i_carry && o_ovf == i_ovf);
        end
        if (mc > 5'd1) begin
            // R9
            ovf_pass_chk: assert (o_ovf == i_ovf);
        end
        if (mc != 5'd0 && i_op == 2'b00) begin
            // R3
            rol_carry_chk: assert (o_carry == o_result[0]);
        end
        if (mc != 5'd0 && i_op == 2'b01) begin
            // R4
            ror_carry_chk: assert (o_carry == top);
        end
        if (mc == 5'd1 && !i_op[0]) begin
            // R7
            left_ovf_chk: assert (o_ovf == (o_carry ^ top));
        end
        if (mc == 5'd1 && i_op[0]) begin
            // R8
            right_ovf_chk: assert (o_ovf == (top ^ top2));
        end
    end
endmodule

bind rot_flag_unit rot_flag_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rot_chk (.*);

// File: tb/test_rot_flag_unit.sv
module test_rot_flag_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] operand;
    logic [1:0]  size;
    logic [7:0]  count;
    logic [1:0]  op;
    logic        cin;
    logic        oin;
    logic [31:0] result;
    logic        cout;
    logic        oout;
    logic        we;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rot_flag_unit i_rot_flag_unit (
        .i_operand(operand), .i_size(size), .i_count(count), .i_op(op),
        .i_carry(cin), .i_ovf(oin), .o_result(result), .o_carry(cout),
        .o_ovf(oout), .o_flag_we(we)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  sz;
        logic [7:0]  cnt;
        logic        c;
        logic        o;
        logic [31:0] v;
        logic [31:0] res;
        logic        co;
        logic        oo;
        logic        we;
    } vec_t;

    localparam logic [80:0] VECS [8] = '{
        {2'd0, 2'd0, 8'd1,    1'b0, 1'b0, 32'h0000_0081, 32'h0000_0003, 1'b1, 1'b1, 1'b1}, // R3 R7
        {2'd1, 2'd0, 8'd1,    1'b0, 1'b0, 32'h0000_0001, 32'h0000_0080, 1'b1, 1'b1, 1'b1}, // R4 R8
        {2'd2, 2'd0, 8'd1,    1'b0, 1'b0, 32'h0000_0080, 32'h0000_0000, 1'b1, 1'b1, 1'b1}, // R5 R7
        {2'd3, 2'd1, 8'd1,    1'b1, 1'b0, 32'h0000_0001, 32'h0000_8000, 1'b1, 1'b1, 1'b1}, // R6 R8
        {2'd0, 2'd2, 8'h24,   1'b0, 1'b1, 32'h1234_5678, 32'h2345_6781, 1'b1, 1'b1, 1'b1}, // R1 R9
        {2'd2, 2'd0, 8'd9,    1'b1, 1'b0, 32'h0000_005A, 32'h0000_005A, 1'b1, 1'b0, 1'b1}, // R5 ring of 9
        {2'd1, 2'd1, 8'h20,   1'b0, 1'b1, 32'h0000_1234, 32'h0000_1234, 1'b0, 1'b1, 1'b0}, // R1 R10 R11
        {2'd0, 2'd0, 8'd8,    1'b0, 1'b0, 32'hFFFF_FF0F, 32'h0000_000F, 1'b1, 1'b0, 1'b1}  // R2 R12
    };

    task automatic ref_rot(input logic [31:0] v, input logic [1:0] sz, input logic [7:0] cnt,
                           input logic [1:0] o_p, input logic c, input logic o,
                           output logic [31:0] r, output logic rc, output logic ro, output logic rw);
        int w;
        int m;
        int k;
        logic b;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m = int'(cnt[4:0]);
        k = m;
        if (o_p[1] && w < 32) k = m % (w + 1);
        r  = (w == 32) ? v : (v & ((32'd1 << w) - 1));
        rc = c;
        for (int s = 0; s < k; s++) begin
            if (!o_p[0]) begin
                b = r[w-1];
                r = (r << 1) & ((w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1));
                r[0] = o_p[1] ? rc : b;
                rc = b;
            end else begin
                b = r[0];
                r = r >> 1;
                r[w-1] = o_p[1] ? rc : b;
                rc = b;
            end
        end
        if (m == 0) rc = c;
        rw = (m != 0);
        if (m == 1) ro = !o_p[0] ? (rc ^ r[w-1]) : (r[w-1] ^ r[w-2]);
        else        ro = o;
    endtask

    task automatic check(input string req, input logic [31:0] er, input logic ec,
                         input logic eo, input logic ew);
        n_run++;
        if (result !== er || cout !== ec || oout !== eo || we !== ew) begin
            n_fail++;
            $display("FAIL %s op=%0d sz=%0d cnt=%0d v=%h: got res=%h c=%b o=%b we=%b exp res=%h c=%b o=%b we=%b",
                     req, op, size, count, operand, result, cout, oout, we, er, ec, eo, ew);
        end
    endtask

    function automatic string op_req(input logic [1:0] o_p);
        case (o_p)
            2'd0:    return "R3";
            2'd1:    return "R4";
            2'd2:    return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] er;
        logic        ec;
        logic        eo;
        logic        ew;
        vec_t        vv;
        logic [31:0] pats [4];
        pats = '{32'hA5C3_0F96, 32'h8000_0001, 32'h0000_0000, 32'h6E21_B7F4};

        // reset: idle inputs, no-op outputs (R10 R11)
        operand = '0; size = 2'b00; count = '0; op = 2'b00; cin = 1'b0; oin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", 32'h0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        // vector table
        for (int i = 0; i < 8; i++) begin
            vv = vec_t'(VECS[i]);
            @(negedge clk);
            op = vv.op; size = vv.sz; count = vv.cnt; cin = vv.c; oin = vv.o; operand = vv.v;
            #1;
            check("R1..vector", vv.res, vv.co, vv.oo, vv.we);
        end

        // R12: plain rotate by multiples of width, right direction, 16-bit by 16
        @(negedge clk);
        op = 2'b01; size = 2'b01; count = 8'd16; cin = 1'b0; oin = 1'b1; operand = 32'h0000_8001;
        #1;
        check("R12", 32'h0000_8001, 1'b1, 1'b1, 1'b1);

        // R5: 16-bit carry rotate by 17 keeps operand and carry
        @(negedge clk);
        op = 2'b10; size = 2'b01; count = 8'd17; cin = 1'b0; oin = 1'b0; operand = 32'h0000_C3A5;
        #1;
        check("R5", 32'h0000_C3A5, 1'b0, 1'b0, 1'b1);

        // R1: upper count bits alone give a no-op
        @(negedge clk);
        op = 2'b11; size = 2'b10; count = 8'hE0; cin = 1'b1; oin = 1'b0; operand = 32'hDEAD_BEEF;
        #1;
        check("R1", 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0);

        // R2: size 2'b11 acts as 32-bit
        @(negedge clk);
        op = 2'b00; size = 2'b11; count = 8'd8; cin = 1'b0; oin = 1'b0; operand = 32'h1234_5678;
        #1;
        check("R2", 32'h3456_7812, 1'b0, 1'b0, 1'b1);

        // full sweep against the stepping model
        for (int sz = 0; sz < 4; sz++) begin
            for (int o_p = 0; o_p < 4; o_p++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int c = 0; c < 2; c++) begin
                        for (int cnt = 0; cnt < 256; cnt++) begin
                            operand = pats[p]; size = 2'(sz); op = 2'(o_p);
                            count = 8'(cnt); cin = c[0]; oin = ~c[0];
                            #1;
                            ref_rot(operand, size, count, op, cin, oin, er, ec, eo, ew);
                            check(op_req(op), er, ec, eo, ew);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule